// File: doc/BRIEF.md
# Configurable External Interrupt Unit

This block is the front end between a bank of asynchronous external request pins and a downstream interrupt controller. Each pin first passes through a two-stage synchroniser. Each line can then be set to sense a level or an edge, with either polarity. Edge events are held in a per-line request flop until software clears them. Level requests follow the pin and are not latched. A per-line mask gates what reaches the controller. Every output is an active-high level, whatever sensing mode the line uses.

Software reaches the unit through a simple 32-bit register port, using a word index, a write strobe and a read strobe. Read data is registered and appears on the cycle after the read strobe. Bit n of every register refers to line n. The word index selects a register as follows:

| Index | Register | Access |
|-------|----------|--------|
| 0 | mask | read/write |
| 1 | source select | read/write |
| 2 | masked status | read-only |
| 3 | raw status | read-only |
| 4 | clear | write-one-to-clear |
| 5 | polarity | read/write |
| 6 | edge select | read/write |
| 7 | software request | read/write |

Top module: `ext_irq_unit`

## Requirements
- R1: After reset, every mask bit is 1 and every polarity bit is 1. The edge-select, source-select and software-request registers read 0. No output is asserted.
- R2: With polarity 1 and edge select 0, a line's raw request follows its synchronised pin while the pin is high. The request drops when the pin returns low, so nothing is latched.
- R3: With polarity 0 and edge select 0, a line's raw request is asserted while its pin is low.
- R4: With polarity 1 and edge select 1, a rising pin edge sets the line's request. The request stays set after the pin falls, until it is cleared.
- R5: With polarity 0 and edge select 1, a falling pin edge sets the line's request. A rising edge does not set it.
- R6: Writing the clear register (index 4) clears each latched request whose written bit is 1. Bits written as 0 leave their requests unchanged.
- R7: If a selected edge and a clear of the same line fall in the same cycle, the request stays set.
- R8: A mask bit of 1 holds that line's output low. An edge seen while the line is masked stays latched, and it drives the output once the mask bit is written to 0.
- R9: Raw status (index 3) reads the request bits before masking. Masked status (index 2) reads the request bits ANDed with the inverted mask. Each output equals its masked status bit, one cycle later.
- R10: A 1 in the software request register (index 7) ORs into that line's request, in every sensing mode.
- R11: The source select register (index 1) is a plain read/write register. It has no effect on the outputs.
- R12: Writes to the two status registers (indices 2 and 3) change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin_i | input | NLINES | Asynchronous external request pins |
| bus_word | input | 3 | Register word index (byte offset bits 4:2) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | NLINES | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | NLINES | Read data, valid the cycle after bus_rd |
| irq_o | output | NLINES | Registered active-high request per line toward the parent controller |

## Verification
The assertions assume that the pins have already passed the synchroniser. They also assume that reset is held for at least one clock edge before release, so that the mask and the latches start from known values. They assume that a write strobe is a single-cycle pulse. The bench drives the pins and the bus strobes only on falling clock edges and never asserts a read and a write together. It times the same-cycle edge and clear case by counting the two synchroniser stages and the edge-detect stage, so that both events reach the request flop on the same rising edge.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int REG_IDX_W = 3;

  typedef enum logic [REG_IDX_W-1:0] {
    RG_MASK  = 3'd0,
    RG_SRC   = 3'd1,
    RG_MSTAT = 3'd2,
    RG_RSTAT = 3'd3,
    RG_CLR   = 3'd4,
    RG_POL   = 3'd5,
    RG_EDGE  = 3'd6,
    RG_SWI   = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ext_irq_line.sv
module ext_irq_line (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  input  logic pol,
  input  logic edg,
  input  logic clr,
  input  logic swi,
  output logic hit,
  output logic lat,
  output logic req
);
  logic prev;
  logic lvl;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= pin_s;
  end

  // Edge taken on the synchronised pin, so a polarity flip makes no edge
  assign hit = edg & (pol ? (pin_s & ~prev) : (~pin_s & prev));
  assign lvl = pol ? pin_s : ~pin_s;

  always_ff @(posedge clk) begin
    if (rst)      lat <= 1'b0;
    else if (edg) lat <= hit | (lat & ~clr);
    else          lat <= 1'b0;
  end

  assign req = swi | (edg ? lat : lvl);
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  reg_sel_e          sel,
  input  logic              wr,
  input  logic [NLINES-1:0] wdata,
  input  logic              rd,
  input  logic [NLINES-1:0] raw_req,
  output logic [NLINES-1:0] mask_q,
  output logic [NLINES-1:0] src_q,
  output logic [NLINES-1:0] pol_q,
  output logic [NLINES-1:0] edg_q,
  output logic [NLINES-1:0] swi_q,
  output logic [NLINES-1:0] clr_vec,
  output logic [NLINES-1:0] rdata
);
  logic [NLINES-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      src_q  <= '0;
      pol_q  <= '1;
      edg_q  <= '0;
      swi_q  <= '0;
    end else if (wr) begin
      case (sel)
        RG_MASK: mask_q <= wdata;
        RG_SRC:  src_q  <= wdata;
        RG_POL:  pol_q  <= wdata;
        RG_EDGE: edg_q  <= wdata;
        RG_SWI:  swi_q  <= wdata;
        default: ;
      endcase
    end
  end

  assign clr_vec = (wr && sel == RG_CLR) ? wdata : '0;

  always_comb begin
    case (sel)
      RG_MASK:  rd_mux = mask_q;
      RG_SRC:   rd_mux = src_q;
      RG_MSTAT: rd_mux = raw_req & ~mask_q;
      RG_RSTAT: rd_mux = raw_req;
      RG_POL:   rd_mux = pol_q;
      RG_EDGE:  rd_mux = edg_q;
      RG_SWI:   rd_mux = swi_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
  import ext_irq_pkg::*;
#(
  parameter int NLINES      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] irq_pin_i,
  input  logic [2:0]        bus_word,
  input  logic              bus_wr,
  input  logic [NLINES-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [NLINES-1:0] bus_rdata,
  output logic [NLINES-1:0] irq_o
);
  logic [NLINES-1:0] pin_s;
  logic [NLINES-1:0] mask_q, src_q, pol_q, edg_q, swi_q, clr_vec;
  logic [NLINES-1:0] hit_vec, lat_vec, raw_req;

  ext_irq_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (irq_pin_i),
    .q   (pin_s)
  );

  ext_irq_regs #(.NLINES(NLINES)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .sel     (reg_sel_e'(bus_word)),
    .wr      (bus_wr),
    .wdata   (bus_wdata),
    .rd      (bus_rd),
    .raw_req (raw_req),
    .mask_q  (mask_q),
    .src_q   (src_q),
    .pol_q   (pol_q),
    .edg_q   (edg_q),
    .swi_q   (swi_q),
    .clr_vec (clr_vec),
    .rdata   (bus_rdata)
  );

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    ext_irq_line u_line (
      .clk   (clk),
      .rst   (rst),
      .pin_s (pin_s[g]),
      .pol   (pol_q[g]),
      .edg   (edg_q[g]),
      .clr   (clr_vec[g]),
      .swi   (swi_q[g]),
      .hit   (hit_vec[g]),
      .lat   (lat_vec[g]),
      .req   (raw_req[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= '0;
    else     irq_o <= raw_req & ~mask_q;
  end
endmodule

// File: rtl/ext_irq_unit_chk.sv
module ext_irq_unit_chk #(
  parameter int NLINES = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [NLINES-1:0] irq_o,
  input logic [NLINES-1:0] mask_q,
  input logic [NLINES-1:0] edg_q,
  input logic [NLINES-1:0] clr_vec,
  input logic [NLINES-1:0] hit_vec,
  input logic [NLINES-1:0] lat_vec,
  input logic [NLINES-1:0] swi_q,
  input logic [NLINES-1:0] raw_req
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mask_q == '1 && irq_o == '0));

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(lat_vec & ~clr_vec & edg_q)) & ~lat_vec) == '0);

  // R7
  edge_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(hit_vec) & ~lat_vec) == '0);

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o & $past(mask_q)) == '0);

  // R10
  soft_req_chk: assert property (@(posedge clk) disable iff (rst)
    (swi_q & ~raw_req) == '0);
endmodule

bind ext_irq_unit ext_irq_unit_chk #(.NLINES(NLINES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .irq_o   (irq_o),
  .mask_q  (mask_q),
  .edg_q   (edg_q),
  .clr_vec (clr_vec),
  .hit_vec (hit_vec),
  .lat_vec (lat_vec),
  .swi_q   (swi_q),
  .raw_req (raw_req)
);

// File: tb/ext_irq_unit_bench.sv
module ext_irq_unit_bench;
  localparam int N = 32;
  localparam logic [2:0] W_MASK = 3'd0, W_SRC = 3'd1, W_MSTAT = 3'd2, W_RSTAT = 3'd3,
                         W_CLR = 3'd4, W_POL = 3'd5, W_EDGE = 3'd6, W_SWI = 3'd7;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] pins = '0;
  logic [2:0]   bus_word = '0;
  logic         bus_wr = 1'b0;
  logic [N-1:0] bus_wdata = '0;
  logic         bus_rd = 1'b0;
  logic [N-1:0] bus_rdata;
  logic [N-1:0] irq_o;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  ext_irq_unit u_ext_irq_unit (
    .clk       (clk),
    .rst       (rst),
    .irq_pin_i (pins),
    .bus_word  (bus_word),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [N-1:0] data);
    @(negedge clk);
    bus_word = idx; bus_wdata = data; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [N-1:0] data);
    @(negedge clk);
    bus_word = idx; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    data = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic restore();
    pins = '0;
    settle();
    wr(W_MASK, '1); wr(W_EDGE, '0); wr(W_POL, '1); wr(W_SWI, '0); wr(W_CLR, '1);
    settle();
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    check("R1 irq_o", irq_o, '0);
    rd(W_MASK, v);  check("R1 mask", v, '1);
    rd(W_POL, v);   check("R1 pol", v, '1);
    rd(W_EDGE, v);  check("R1 edge", v, '0);
    rd(W_SRC, v);   check("R1 src", v, '0);
    rd(W_SWI, v);   check("R1 swi", v, '0);
  endtask

  task automatic t_level_high();
    logic [N-1:0] v;
    wr(W_MASK, ~(32'h1 << 3));
    pins[3] = 1'b1; settle();
    rd(W_RSTAT, v); check("R2 raw high", v, 32'h1 << 3);
    check("R2 irq high", irq_o, 32'h1 << 3);
    pins[3] = 1'b0; settle();
    rd(W_RSTAT, v); check("R2 raw drops", v, '0);
    check("R2 irq drops", irq_o, '0);
    restore();
  endtask

  task automatic t_level_low();
    logic [N-1:0] v;
    wr(W_POL, ~(32'h1 << 5)); wr(W_MASK, ~(32'h1 << 5)); settle();
    rd(W_RSTAT, v); check("R3 raw low", v, 32'h1 << 5);
    check("R3 irq low", irq_o, 32'h1 << 5);
    pins[5] = 1'b1; settle();
    rd(W_RSTAT, v); check("R3 raw when high", v, '0);
    restore();
  endtask

  task automatic t_rise_and_clear();
    logic [N-1:0] v;
    wr(W_EDGE, 32'h1 << 7); wr(W_CLR, '1); wr(W_MASK, ~(32'h1 << 7)); settle();
    pins[7] = 1'b1; settle();
    check("R4 irq on rise", irq_o, 32'h1 << 7);
    pins[7] = 1'b0; settle();
    rd(W_RSTAT, v); check("R4 held after fall", v, 32'h1 << 7);
    wr(W_CLR, ~(32'h1 << 7)); settle();
    rd(W_RSTAT, v); check("R6 zero bit no effect", v, 32'h1 << 7);
    wr(W_CLR, 32'h1 << 7); settle();
    rd(W_RSTAT, v); check("R6 cleared", v, '0);
    check("R6 irq cleared", irq_o, '0);
    restore();
  endtask

  task automatic t_fall();
    logic [N-1:0] v;
    wr(W_EDGE, 32'h1 << 9); wr(W_POL, ~(32'h1 << 9));
    pins[9] = 1'b1; settle();
    wr(W_CLR, '1); settle();
    rd(W_RSTAT, v); check("R5 no set on rise", v, '0);
    pins[9] = 1'b0; settle();
    rd(W_RSTAT, v); check("R5 set on fall", v, 32'h1 << 9);
    restore();
  endtask

  task automatic t_race();
    logic [N-1:0] v;
    wr(W_EDGE, 32'h1 << 13); wr(W_CLR, '1);
    pins[13] = 1'b1; settle();
    pins[13] = 1'b0; settle();
    // edge reaches the request flop two rising edges after the pin, plus one
    @(negedge clk); pins[13] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(W_CLR, 32'h1 << 13);
    settle();
    rd(W_RSTAT, v); check("R7 edge beats clear", v, 32'h1 << 13);
    wr(W_CLR, 32'h1 << 13); settle();
    rd(W_RSTAT, v); check("R7 later clear works", v, '0);
    restore();
  endtask

  task automatic t_mask_latch();
    logic [N-1:0] v;
    wr(W_EDGE, 32'h1 << 11); wr(W_CLR, '1);
    pins[11] = 1'b1; settle(); pins[11] = 1'b0; settle();
    rd(W_RSTAT, v); check("R8 raw while masked", v, 32'h1 << 11);
    rd(W_MSTAT, v); check("R8 mstat while masked", v, '0);
    check("R8 irq masked", irq_o, '0);
    wr(W_MASK, ~(32'h1 << 11)); settle();
    check("R8 irq after unmask", irq_o, 32'h1 << 11);
    restore();
  endtask

  task automatic t_mstat();
    logic [N-1:0] v;
    pins[2:0] = 3'b111;
    wr(W_MASK, ~32'h2); settle();
    rd(W_RSTAT, v); check("R9 raw", v, 32'h7);
    rd(W_MSTAT, v); check("R9 masked", v, 32'h7 & 32'h2);
    check("R9 irq equals mstat", irq_o, 32'h2);
    restore();
  endtask

  task automatic t_swi();
    logic [N-1:0] v;
    wr(W_SWI, 32'h1 << 20); settle();
    rd(W_RSTAT, v); check("R10 raw from swi", v, 32'h1 << 20);
    check("R10 masked swi quiet", irq_o, '0);
    wr(W_EDGE, 32'h1 << 20); wr(W_MASK, ~(32'h1 << 20)); wr(W_CLR, '1); settle();
    check("R10 swi in edge mode", irq_o, 32'h1 << 20);
    wr(W_SWI, '0); settle();
    rd(W_RSTAT, v); check("R10 swi removed", v, '0);
    restore();
  endtask

  task automatic t_src_and_ro();
    logic [N-1:0] v;
    wr(W_MASK, '0);
    wr(W_SRC, 32'hA5A5_0F0F); settle();
    rd(W_SRC, v); check("R11 src readback", v, 32'hA5A5_0F0F);
    check("R11 src no effect", irq_o, '0);
    wr(W_RSTAT, '1); wr(W_MSTAT, '1); settle();
    rd(W_RSTAT, v); check("R12 raw read-only", v, '0);
    rd(W_MSTAT, v); check("R12 mstat read-only", v, '0);
    check("R12 irq unchanged", irq_o, '0);
    rd(W_MASK, v); check("R12 mask untouched", v, '0);
    restore();
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_level_high();
    t_level_low();
    t_rise_and_clear();
    t_fall();
    t_race();
    t_mask_latch();
    t_mstat();
    t_swi();
    t_src_and_ro();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule